// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This unit sits between a 32-bit core and a data memory whose write port has one enable per byte. On a store it turns the byte offset and the access size into lane strobes and places the store value in the lanes. A byte value is copied into every lane and a halfword value into both halves, so whichever lanes are enabled carry the right bits. On a load it picks the addressed byte or halfword out of the memory word and widens it to 32 bits. Signed loads copy the field's top bit into the upper bits, and unsigned loads fill them with zeros.

Any access whose offset does not suit its size is reported as misaligned. Such an access enables no lanes and returns no load data. The unit takes its inputs in one cycle and presents its results, registered, in the next cycle. Lane 0 holds bits 7:0 and is selected by offset 0, so the lane mapping is little-endian.

Top module: `lsa_unit`

## Requirements
- R1: While rst_n is low, mem_wstrb, mem_wdata, load_data and misaligned are all zero.
- R2: A byte store (req_size 2'b00) at any offset raises only strobe bit req_ofs, where bit 0 covers data bits 7:0. mem_wdata holds req_wdata[7:0] in all four bytes.
- R3: A halfword store (req_size 2'b01) with req_ofs[0]=0 gives strobes 4'b0011 when req_ofs[1]=0 and 4'b1100 when req_ofs[1]=1. mem_wdata holds req_wdata[15:0] in both halves.
- R4: A word store (req_size 2'b10) at offset 0 gives strobes 4'b1111, and mem_wdata equals req_wdata.
- R5: A request is misaligned if it is a halfword with req_ofs[0]=1, a word with a nonzero req_ofs, or uses size code 2'b11. A misaligned request sets misaligned to 1 and gives zero strobes, zero mem_wdata and zero load_data.
- R6: A signed load takes byte req_ofs (bits 8*req_ofs+7 down to 8*req_ofs) or halfword req_ofs[1] (bits 16*req_ofs[1]+15 down to 16*req_ofs[1]) from mem_rdata. It then copies the field's top bit into every upper bit.
- R7: An unsigned byte or halfword load returns the same field with its upper bits zero. A word load returns mem_rdata unchanged whatever req_signed is.
- R8: Results appear one clock after the request. Outputs are all zero after a cycle with req_valid low. A load drives no strobes and zero mem_wdata, and a store drives zero load_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ofs | input | 2 | Byte offset within the word (low address bits) |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Word read from memory |
| mem_wstrb | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| load_data | output | 32 | Extracted and extended load value |
| misaligned | output | 1 | Access offset illegal for its size |

## Verification
On every cycle the assertions check several properties against the request of the cycle before. They check the strobe population for each store size: one lane for a byte, two for a halfword and four for a word. They check that a misaligned result never carries strobes or load data, that unsigned byte loads have zero upper bits, and that an idle cycle leaves the outputs quiet. The assertions do not check which lane a strobe selects, the replicated store pattern or the sign-extended values. Those are shown only by the bench, whose reference model is compared with all outputs on every clock across directed lane sweeps, misalignment cases and random traffic.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        LSA_BYTE = 2'b00,
        LSA_HALF = 2'b01,
        LSA_WORD = 2'b10,
        LSA_RSVD = 2'b11
    } lsa_size_e;
endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
    import lsa_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  lsa_size_e        size,
    input  logic [OFS_W-1:0] ofs,
    output logic             bad
);
    always_comb begin
        unique case (size)
            LSA_BYTE: bad = 1'b0;
            LSA_HALF: bad = ofs[0];
            LSA_WORD: bad = (ofs != '0);
            default:  bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              en,
    input  lsa_size_e         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [NBYTES-1:0] strb,
    output logic [DATA_W-1:0] data
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE = OFS_W'(g);
        always_comb begin
            unique case (size)
                LSA_BYTE: strb[g] = en && (ofs == LANE);
                LSA_HALF: strb[g] = en && ((ofs >> 1) == (LANE >> 1));
                LSA_WORD: strb[g] = en;
                default:  strb[g] = 1'b0;
            endcase
        end
    end

    always_comb begin
        data = '0;
        if (en) begin
            unique case (size)
                LSA_BYTE: data = {NBYTES{wdata[7:0]}};
                LSA_HALF: data = {(NBYTES/2){wdata[15:0]}};
                LSA_WORD: data = wdata;
                default:  data = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              en,
    input  lsa_size_e         size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              sgn,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] byte_sh;
    logic [DATA_W-1:0] half_sh;
    logic [7:0]        fb;
    logic [15:0]       fh;

    always_comb begin
        byte_sh = rdata >> {ofs, 3'b000};
        half_sh = rdata >> {ofs[OFS_W-1:1], 4'b0000};
        fb      = byte_sh[7:0];
        fh      = half_sh[15:0];
        data    = '0;
        if (en) begin
            unique case (size)
                LSA_BYTE: data = {{(DATA_W-8){sgn & fb[7]}}, fb};
                LSA_HALF: data = {{(DATA_W-16){sgn & fh[15]}}, fh};
                LSA_WORD: data = rdata;
                default:  data = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NBYTES-1:0] mem_wstrb,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] load_data,
    output logic              misaligned
);
    typedef struct packed {
        logic [NBYTES-1:0] strb;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] ldata;
        logic              err;
    } lsa_state_t;

    lsa_state_t        st_d, st_q;
    lsa_size_e         size;
    logic              bad;
    logic              st_en, ld_en;
    logic [NBYTES-1:0] strb_c;
    logic [DATA_W-1:0] wdata_c, ldata_c;

    assign size = lsa_size_e'(req_size);

    lsa_align_chk #(.OFS_W(OFS_W)) u_align (
        .size (size),
        .ofs  (req_ofs),
        .bad  (bad)
    );

    assign st_en = req_valid && req_write && !bad;
    assign ld_en = req_valid && !req_write && !bad;

    lsa_store_lanes #(.DATA_W(DATA_W)) u_store (
        .en    (st_en),
        .size  (size),
        .ofs   (req_ofs),
        .wdata (req_wdata),
        .strb  (strb_c),
        .data  (wdata_c)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .en    (ld_en),
        .size  (size),
        .ofs   (req_ofs),
        .sgn   (req_signed),
        .rdata (mem_rdata),
        .data  (ldata_c)
    );

    always_comb begin
        st_d       = '0;
        st_d.strb  = strb_c;
        st_d.wdata = wdata_c;
        st_d.ldata = ldata_c;
        st_d.err   = req_valid && bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_wstrb  = st_q.strb;
    assign mem_wdata  = st_q.wdata;
    assign load_data  = st_q.ldata;
    assign misaligned = st_q.err;
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [OFS_W-1:0]  req_ofs,
    input logic [1:0]        req_size,
    input logic              req_signed,
    input logic [NBYTES-1:0] mem_wstrb,
    input logic [DATA_W-1:0] load_data,
    input logic              misaligned
);
    p_byte_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_size == 2'b00) |-> $countones(mem_wstrb) == 1);

    p_half_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_size == 2'b01 && !req_ofs[0])
        |-> $countones(mem_wstrb) == 2);

    p_word_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_size == 2'b10 && req_ofs == '0)
        |-> mem_wstrb == '1);

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_wstrb == '0 && load_data == '0));

    p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && !req_signed && req_size == 2'b00)
        |-> load_data[DATA_W-1:8] == '0);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (mem_wstrb == '0 && !misaligned && load_data == '0));
endmodule

bind lsa_unit lsa_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ofs    (req_ofs),
    .req_size   (req_size),
    .req_signed (req_signed),
    .mem_wstrb  (mem_wstrb),
    .load_data  (load_data),
    .misaligned (misaligned)
);

// File: tb/tb_lsa_unit.sv
`timescale 1ns/1ps
module tb_lsa_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_ofs = '0, req_size = '0;
    logic [31:0] req_wdata = '0, mem_rdata = '0;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata, load_data;
    logic        misaligned;

    int vectors = 0, fails = 0;
    logic [68:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    lsa_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ofs(req_ofs), .req_size(req_size), .req_signed(req_signed),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .load_data(load_data), .misaligned(misaligned)
    );

    function automatic logic [68:0] model(input logic v, input logic w, input logic [1:0] o,
                                          input logic [1:0] sz, input logic sg,
                                          input logic [31:0] wd, input logic [31:0] rd);
        logic [3:0]  s = '0;
        logic [31:0] d = '0, ld = '0;
        int unsigned fld;
        logic        bad;
        bad = (sz == 2'd3) || (sz == 2'd1 && o[0]) || (sz == 2'd2 && o != 2'd0);
        if (!v) return '0;
        if (bad) return {4'h0, 32'h0, 32'h0, 1'b1};
        if (w) begin
            case (sz)
                2'd0: begin s = 4'b0001 << o; d = (wd & 32'hFF) * 32'h0101_0101; end
                2'd1: begin s = o[1] ? 4'b1100 : 4'b0011; d = (wd & 32'hFFFF) * 32'h0001_0001; end
                default: begin s = 4'hF; d = wd; end
            endcase
        end else begin
            case (sz)
                2'd0: begin
                    fld = (rd >> (8 * o)) & 32'hFF;
                    ld = (sg && fld >= 128) ? fld - 256 : fld;
                end
                2'd1: begin
                    fld = (rd >> (16 * o[1])) & 32'hFFFF;
                    ld = (sg && fld >= 32768) ? fld - 65536 : fld;
                end
                default: ld = rd;
            endcase
        end
        return {s, d, ld, 1'b0};
    endfunction

    function automatic string tag_of(input logic v, input logic w, input logic [1:0] o,
                                     input logic [1:0] sz, input logic sg);
        if (!v) return "R8";
        if (sz == 2'd3 || (sz == 2'd1 && o[0]) || (sz == 2'd2 && o != 0)) return "R5";
        if (w) return (sz == 0) ? "R2" : (sz == 1) ? "R3" : "R4";
        if (sz == 2'd2 || !sg) return "R7";
        return "R6";
    endfunction

    task automatic compare(input logic [68:0] e, input string t);
        logic [68:0] a;
        a = {mem_wstrb, mem_wdata, load_data, misaligned};
        vectors++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s: strb/wdata/ldata/err actual %h %h %h %b expected %h %h %h %b",
                     t, a[68:65], a[64:33], a[32:1], a[0], e[68:65], e[64:33], e[32:1], e[0]);
        end
    endtask

    task automatic apply(input logic v, input logic w, input logic [1:0] o, input logic [1:0] sz,
                         input logic sg, input logic [31:0] wd, input logic [31:0] rd);
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        req_valid = v; req_write = w; req_ofs = o; req_size = sz;
        req_signed = sg; req_wdata = wd; mem_rdata = rd;
        exp_q.push_back(model(v, w, o, sz, sg, wd, rd));
        tag_q.push_back(tag_of(v, w, o, sz, sg));
    endtask

    initial begin : watchdog
        #(4ns * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: outputs stay zero while reset is held, even with a live store
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare('0, "R1");
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(0, 0, 0, 0, 0, 32'h0, 32'h0);                // R8 idle
        apply(0, 1, 2, 2, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R8 ignored fields
        for (int o = 0; o < 4; o++)                          // R2 every lane
            apply(1, 1, 2'(o), 0, 0, 32'h1234_56A5 + 32'(o), 32'h0);
        apply(1, 1, 0, 1, 0, 32'hABCD_BEEF, 32'h0);          // R3 low half
        apply(1, 1, 2, 1, 0, 32'h1111_C0DE, 32'h0);          // R3 high half
        apply(1, 1, 0, 2, 0, 32'hCAFE_F00D, 32'h0);          // R4 word
        apply(1, 1, 1, 1, 0, 32'h5555_5555, 32'h0);          // R5 odd halfword store
        apply(1, 1, 2, 2, 0, 32'h5555_5555, 32'h0);          // R5 word at offset 2
        apply(1, 0, 3, 2, 1, 32'h0, 32'hFFFF_FFFF);          // R5 word load at offset 3
        apply(1, 0, 0, 3, 0, 32'h0, 32'hFFFF_FFFF);          // R5 reserved size
        for (int o = 0; o < 4; o++) begin                    // R6 / R7 byte loads
            apply(1, 0, 2'(o), 0, 1, 32'h0, 32'h80_7F_FF_01);
            apply(1, 0, 2'(o), 0, 0, 32'h0, 32'h80_7F_FF_01);
        end
        apply(1, 0, 0, 1, 1, 32'h0, 32'h7FFF_8001);          // R6 negative halfword
        apply(1, 0, 2, 1, 1, 32'h0, 32'h7FFF_8001);          // R6 positive halfword
        apply(1, 0, 2, 1, 0, 32'h0, 32'hF00F_8001);          // R7 unsigned halfword
        apply(1, 0, 0, 2, 1, 32'h0, 32'h8000_0001);          // R7 word ignores signed
        apply(1, 0, 0, 2, 0, 32'h0, 32'h8000_0001);          // R7 word unsigned
        for (int i = 0; i < 400; i++)                        // R2..R8 random mix
            apply(1'($urandom_range(0, 5) != 0), 1'($urandom), 2'($urandom), 2'($urandom),
                  1'($urandom), $urandom, $urandom);
        apply(0, 0, 0, 0, 0, 32'h0, 32'h0);                  // R8 flush
        @(negedge clk);
        compare(exp_q.pop_front(), tag_q.pop_front());
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule